// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Greater-or-Equal Flags

This block performs unsigned arithmetic on packed lanes of two 32-bit operands. It returns a 32-bit packed result and a 4-bit greater-or-equal flag vector that records the carry or borrow of every lane. A 2-bit operation select picks one of three operations:
- byte-lane addition;
- byte-lane subtraction;
- a halfword exchange form, which adds across the operands' opposite halves in the low half and subtracts across them in the high half.

An issue strobe together with a condition-pass input decides whether an operation commits. A committed operation updates the result register and the flag register on the next clock edge, and raises one-cycle valid and flag-write indications. An operation that does not commit leaves both registers unchanged. The result can feed a register file write port, and the flag vector can feed a later byte-select operation.

Top module: `lane_arith_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, resultValid, geWrite, resultData and geFlags are all zero.
- R2: With opSel = 2'b00 committed, each byte lane i of resultData (bits [8i+7:8i]) is the low 8 bits of opA lane i plus opB lane i.
- R3: With opSel = 2'b00 committed, geFlags bit i is 1 exactly when the lane i sum is 0x100 or more.
- R4: With opSel = 2'b01 committed, each byte lane i of resultData is the low 8 bits of opA lane i minus opB lane i.
- R5: With opSel = 2'b01 committed, geFlags bit i is 1 exactly when opA lane i is greater than or equal to opB lane i, that is, when no borrow occurs.
- R6: With opSel = 2'b10 committed, resultData[15:0] is the low 16 bits of opA[15:0] + opB[31:16].
- R7: With opSel = 2'b10 committed, resultData[31:16] is the low 16 bits of opA[31:16] − opB[15:0].
- R8: With opSel = 2'b10 committed, geFlags[1:0] are both 1 when the low-half sum is 0x10000 or more, and both 0 otherwise. geFlags[3:2] are both 1 when opA[31:16] ≥ opB[15:0], and both 0 otherwise.
- R9: An operation commits when issueValid and condPass are both 1 on a clock edge and opSel is 00, 01 or 10. resultValid and geWrite are then 1 for exactly the following cycle, and resultData and geFlags change at that same edge.
- R10: When issueValid or condPass is 0 at an edge, resultValid and geWrite are 0 in the following cycle, and resultData and geFlags keep their values.
- R11: opSel = 2'b11 is reserved. It never commits, and it behaves as in R10 even when issueValid and condPass are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented this cycle |
| condPass | input | 1 | The presented operation's condition holds |
| opSel | input | 2 | 00 byte add, 01 byte subtract, 10 halfword exchange, 11 reserved |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| resultValid | output | 1 | resultData was written by the previous edge |
| resultData | output | 32 | Registered packed result |
| geWrite | output | 1 | geFlags was written by the previous edge |
| geFlags | output | 4 | Registered greater-or-equal flags, bit i for lane i |

## Verification
Every result is due one cycle after its stimulus. The edge that samples the operands also loads resultData and geFlags, and it raises resultValid and geWrite for the cycle that follows. The bench drives inputs on the falling edge and checks at the next falling edge. There, it compares all four outputs with a reference that it advanced only for the edge in between. Non-committing cycles are checked in the same way against the held values, so a stray update shows up in the cycle it happens.

// File: rtl/lane_arith_pkg.sv
package lane_arith_pkg;
  typedef enum logic [1:0] {
    OP_BYTE_ADD  = 2'b00,
    OP_BYTE_SUB  = 2'b01,
    OP_HALF_EXCH = 2'b10,
    OP_RESERVED  = 2'b11
  } laneOp_e;

  typedef struct packed {
    logic commit;
    logic subtract;
    logic exchange;
  } laneStrobe_t;
endpackage

// File: rtl/lane_arith_ctrl.sv
module lane_arith_ctrl
  import lane_arith_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic        condPass,
  input  logic [1:0]  opSel,
  output laneStrobe_t strb
);
  logic goAhead;
  assign goAhead = issueValid && condPass;

  always_comb begin
    strb = '0;
    case (laneOp_e'(opSel))
      OP_BYTE_ADD:  strb.commit = goAhead;
      OP_BYTE_SUB: begin
        strb.commit   = goAhead;
        strb.subtract = 1'b1;
      end
      OP_HALF_EXCH: begin
        strb.commit   = goAhead;
        strb.exchange = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  // R10
  no_commit_on_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(issueValid && condPass) |-> !strb.commit);

  // R11
  reserved_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b11) |-> !strb.commit);

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.subtract && strb.exchange));
endmodule

// File: rtl/lane_arith_dpath.sv
module lane_arith_dpath
  import lane_arith_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANE_N = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  laneStrobe_t                strb,
  input  logic [LANE_W*LANE_N-1:0]   opA,
  input  logic [LANE_W*LANE_N-1:0]   opB,
  output logic                       resultValid,
  output logic [LANE_W*LANE_N-1:0]   resultData,
  output logic                       geWrite,
  output logic [LANE_N-1:0]          geFlags
);
  localparam int DATA_W  = LANE_W * LANE_N;
  localparam int HALF_W  = DATA_W / 2;
  localparam int GE_HALF = LANE_N / 2;

  logic [DATA_W-1:0] byteRes;
  logic [LANE_N-1:0] byteGe;

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    logic [LANE_W:0] wide;
    assign wide = strb.subtract
      ? ({1'b0, opA[i*LANE_W +: LANE_W]} - {1'b0, opB[i*LANE_W +: LANE_W]})
      : ({1'b0, opA[i*LANE_W +: LANE_W]} + {1'b0, opB[i*LANE_W +: LANE_W]});
    assign byteRes[i*LANE_W +: LANE_W] = wide[LANE_W-1:0];
    assign byteGe[i] = strb.subtract ? ~wide[LANE_W] : wide[LANE_W];
  end

  logic [HALF_W:0]   lowSum;
  logic [HALF_W:0]   highDiff;
  logic [DATA_W-1:0] exchRes;
  logic [LANE_N-1:0] exchGe;

  assign lowSum   = {1'b0, opA[HALF_W-1:0]} + {1'b0, opB[DATA_W-1:HALF_W]};
  assign highDiff = {1'b0, opA[DATA_W-1:HALF_W]} - {1'b0, opB[HALF_W-1:0]};
  assign exchRes  = {highDiff[HALF_W-1:0], lowSum[HALF_W-1:0]};
  assign exchGe   = {{GE_HALF{~highDiff[HALF_W]}}, {GE_HALF{lowSum[HALF_W]}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      geWrite     <= 1'b0;
      resultData  <= '0;
      geFlags     <= '0;
    end else begin
      resultValid <= strb.commit;
      geWrite     <= strb.commit;
      if (strb.commit) begin
        resultData <= strb.exchange ? exchRes : byteRes;
        geFlags    <= strb.exchange ? exchGe  : byteGe;
      end
    end
  end

  // R10
  ge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(geFlags) && !geWrite));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(resultData) && !resultValid));

  // R8
  exch_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.exchange) |=>
      (geFlags[GE_HALF-1:0] == {GE_HALF{geFlags[0]}}) &&
      (geFlags[LANE_N-1:GE_HALF] == {GE_HALF{geFlags[GE_HALF]}}));

  // R9
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (resultValid && geWrite));
endmodule

// File: rtl/lane_arith_unit.sv
module lane_arith_unit
  import lane_arith_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANE_N = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     issueValid,
  input  logic                     condPass,
  input  logic [1:0]               opSel,
  input  logic [LANE_W*LANE_N-1:0] opA,
  input  logic [LANE_W*LANE_N-1:0] opB,
  output logic                     resultValid,
  output logic [LANE_W*LANE_N-1:0] resultData,
  output logic                     geWrite,
  output logic [LANE_N-1:0]        geFlags
);
  laneStrobe_t strb;

  lane_arith_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .condPass(condPass),
    .opSel(opSel), .strb(strb)
  );

  lane_arith_dpath #(.LANE_W(LANE_W), .LANE_N(LANE_N)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .resultValid(resultValid), .resultData(resultData),
    .geWrite(geWrite), .geFlags(geFlags)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!resultValid && !geWrite));
endmodule

// File: tb/lane_arith_unit_bench.sv
module lane_arith_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, condPass = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic resultValid, geWrite;
  logic [31:0] resultData;
  logic [3:0] geFlags;

  always #2.5 clk = ~clk;

  lane_arith_unit u_lane_arith_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .condPass(condPass),
    .opSel(opSel), .opA(opA), .opB(opB), .resultValid(resultValid),
    .resultData(resultData), .geWrite(geWrite), .geFlags(geFlags)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  logic expValid = 0, expWrite = 0;
  logic [31:0] expData = '0;
  logic [3:0] expGe = '0;
  string dataTag = "R1", geTag = "R1", flagTag = "R1";

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(flagTag, "resultValid", resultValid, expValid);
    check(flagTag, "geWrite", geWrite, expWrite);
    check(dataTag, "resultData", resultData, expData);
    check(geTag, "geFlags", geFlags, expGe);
  endtask

  // advance reference for one edge with the given inputs
  task automatic model(bit iv, bit cp, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    bit go = iv && cp && (op != 2'b11);
    expValid = go;
    expWrite = go;
    if (!go) begin
      flagTag = (op == 2'b11 && iv && cp) ? "R11" : "R10";
      dataTag = flagTag; geTag = flagTag;
      return;
    end
    flagTag = "R9";
    case (op)
      2'b00: begin
        dataTag = "R2"; geTag = "R3";
        for (int i = 0; i < 4; i++) begin
          int s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]);
          expData[8*i +: 8] = s[7:0];
          expGe[i] = (s >= 256);
        end
      end
      2'b01: begin
        dataTag = "R4"; geTag = "R5";
        for (int i = 0; i < 4; i++) begin
          int d = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
          expData[8*i +: 8] = d[7:0];
          expGe[i] = (d >= 0);
        end
      end
      default: begin
        int s = int'(a[15:0]) + int'(b[31:16]);
        int d = int'(a[31:16]) - int'(b[15:0]);
        dataTag = "R6/R7"; geTag = "R8";
        expData = {d[15:0], s[15:0]};
        expGe = {(d >= 0), (d >= 0), (s >= 65536), (s >= 65536)};
      end
    endcase
  endtask

  // one cycle: check outputs of previous edge, then present new inputs
  task automatic step(bit iv, bit cp, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    compareAll();
    issueValid = iv; condPass = cp; opSel = op; opA = a; opB = b;
    model(iv, cp, op, a, b);
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compareAll();  // R1 during reset
    end
    rstN = 1'b1;
    // R1 first cycle after reset, no stimulus
    step(0, 0, 2'b00, 32'h0, 32'h0);
    // R2/R3 carries in some lanes
    step(1, 1, 2'b00, 32'hFF80_0110, 32'h0180_02F0);
    step(1, 1, 2'b00, 32'h0000_0000, 32'h0000_0000);
    step(1, 1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R4/R5 equal, borrow, mix
    step(1, 1, 2'b01, 32'h1234_5678, 32'h1234_5678);
    step(1, 1, 2'b01, 32'h0010_FF01, 32'h0120_0002);
    // R6/R7/R8 exchange
    step(1, 1, 2'b10, 32'h0005_FFFF, 32'h0001_0006);
    step(1, 1, 2'b10, 32'h0003_1234, 32'h1111_0004);
    step(1, 1, 2'b10, 32'h8000_0000, 32'h0000_8000);
    // R10 condition fail and no issue: outputs must hold
    step(1, 0, 2'b00, 32'hFFFF_FFFF, 32'h0101_0101);
    step(0, 1, 2'b01, 32'h0000_0000, 32'h0101_0101);
    // R11 reserved opcode ignored
    step(1, 1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 1, 2'b11, 32'h0000_0001, 32'h0000_0002);
    // back-to-back commits then mixed traffic
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0,
           2'($urandom_range(0, 3)), $urandom, $urandom);
    step(0, 0, 2'b00, 32'h0, 32'h0);
    step(0, 0, 2'b00, 32'h0, 32'h0);
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end
endmodule